// File: doc/BRIEF.md
# Host Watchdog with Safety-Timer Escalation

This block supervises whether a host processor is still in control of a battery charger. It stays dormant after reset. It arms itself once the host is expected to be running. That moment comes with the first host refresh strobe or when the cell voltage comparator reports the cell above the weak-battery level, whichever happens first. Once armed, the host must refresh it within a programmable number of ticks. If it does not, the watchdog has expired, which points to a software failure.

When the watchdog expires while the charger is active, the block escalates. It starts a second, independent safety timer that bounds how much longer charging may go on. When that timer reaches its own programmable length, a sticky timeout flag is raised for the charger control logic to act on. Both periods arrive as input buses counted in tick units, so one slow enable pulse sets the time base for both counters. Both flags are cleared by a fault-recovery strobe.

Top module: `host_wdt_supervisor`

## Requirements
- R1: While not armed, ticks have no effect: no expiry occurs and the safety timer never starts.
- R2: The block arms on the first rising edge of `host_refresh` or on any cycle where `cell_above_weak` is high, and `wdt_armed` then stays 1 until reset, even if the cell drops below the weak level again.
- R3: Once armed with period P, `wdt_expired` rises on the clock edge of the P-th tick after the last restart. The period is sampled only when the count restarts, which happens on arming, on a refresh and on an expiry. A period of 0 behaves as 1.
- R4: A rising edge of `host_refresh` restarts the count. Holding the bit high counts as one refresh, and a refresh in the same cycle as a tick takes priority, so that tick is not counted.
- R5: `wdt_expired` stays 1 until reset or `fault_recover`. A later refresh does not clear it.
- R6: An expiry while `charger_active` is 1 sets `safe_running` on the same clock edge. An expiry while `charger_active` is 0 sets only `wdt_expired`.
- R7: With safety period S, `safe_running` falls and `safe_timeout` rises on the edge of the S-th tick after the safety timer started (period 0 behaves as 1). Further expiries neither restart nor extend the safety timer while it is running or timed out.
- R8: `fault_recover` clears `wdt_expired`, `safe_running` and `safe_timeout` on the next edge, leaves `wdt_armed` unchanged, and lets a later active expiry start the safety timer again.
- R9: After reset all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Time-base enable, one pulse per tick |
| host_refresh | input | 1 | Host refresh bit, edge detected |
| cell_above_weak | input | 1 | Cell voltage is above the weak-battery level |
| charger_active | input | 1 | Charger is currently charging |
| fault_recover | input | 1 | Fault-recovery strobe, clears the flags |
| wdt_period | input | CNT_W | Watchdog period in ticks |
| safe_period | input | CNT_W | Safety timer period in ticks |
| wdt_armed | output | 1 | Watchdog has been armed |
| wdt_expired | output | 1 | Sticky watchdog expiry flag |
| safe_running | output | 1 | Safety timer is counting |
| safe_timeout | output | 1 | Sticky safety timeout flag |

## Verification
The bench sweeps every small pair of watchdog and safety periods with both arming causes and both charger states. An off-by-one counter would move the expiry or timeout by one tick, and a safety timer that ignored the charger state would start while the charger is idle. Directed cases target the remaining corners:
- A held refresh bit: a level-sensitive design would never expire.
- A refresh coinciding with a tick: if the tick won, expiry would come one tick early.
- A period changed in mid-count: sampling it continuously would shift the expiry.
- A zero period.
- Repeated expiries after a timeout: a design that restarted on them would drop the timeout.
- Recovery: if it also disarmed the block, the watchdog would go silent.

// File: rtl/hwd_pkg.sv
// Shared types for the host watchdog supervisor.
package hwd_pkg;
    // Safety timer phases: waiting for escalation, counting, expired.
    typedef enum logic [1:0] {
        SF_IDLE = 2'd0,
        SF_RUN  = 2'd1,
        SF_DONE = 2'd2
    } safe_state_t;
endpackage

// File: rtl/hwd_edge.sv
// Rising-edge detector for the host refresh bit.
// Assumes the level input is synchronous to clk.
module hwd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic level_q;

    // Remember the previous level of the bit.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/hwd_watchdog.sv
// Watchdog core: arming latch, tick counter and sticky expiry flag.
// The period is sampled when the count restarts (arm, refresh, expiry).
// A refresh wins over a tick in the same cycle. A period of 0 acts as 1.
module hwd_watchdog #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             refresh_rise,
    input  logic             cell_above_weak,
    input  logic             recover,
    input  logic [CNT_W-1:0] period,
    output logic             armed,
    output logic             expired,
    output logic             expire_pulse
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_q;
    logic             arm_now;
    logic             restart;
    logic             hit;

    assign arm_now      = !armed && (refresh_rise || cell_above_weak);
    assign hit          = ({1'b0, cnt_q} + EXT_W'(1)) >= {1'b0, per_q};
    assign expire_pulse = armed && tick && !refresh_rise && hit;
    assign restart      = arm_now || (armed && refresh_rise) || expire_pulse;

    // Arming latch: set once, held until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed <= 1'b0;
        else if (arm_now) armed <= 1'b1;
    end

    // Tick counter with period capture on every restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            per_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
            per_q <= period;
        end else if (armed && tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Sticky expiry flag, cleared by recovery.
    always_ff @(posedge clk) begin
        if (!rst_n)            expired <= 1'b0;
        else if (recover)      expired <= 1'b0;
        else if (expire_pulse) expired <= 1'b1;
    end
endmodule

// File: rtl/hwd_safety.sv
// Safety timer started by an escalation request. It counts ticks up to a
// period sampled at start, then holds a timeout until recovery.
// Start requests are ignored unless the timer is idle.
module hwd_safety
    import hwd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             recover,
    input  logic [CNT_W-1:0] period,
    output logic             running,
    output logic             timeout
);
    localparam int EXT_W = CNT_W + 1;

    safe_state_t      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_q;
    logic             hit;

    assign hit = ({1'b0, cnt_q} + EXT_W'(1)) >= {1'b0, per_q};

    // Phase sequencing and tick counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SF_IDLE;
            cnt_q   <= '0;
            per_q   <= '0;
        end else if (recover) begin
            state_q <= SF_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SF_IDLE: if (start) begin
                    state_q <= SF_RUN;
                    cnt_q   <= '0;
                    per_q   <= period;
                end
                SF_RUN: if (tick) begin
                    if (hit) state_q <= SF_DONE;
                    else     cnt_q   <= cnt_q + CNT_W'(1);
                end
                default: state_q <= state_q;
            endcase
        end
    end

    assign running = (state_q == SF_RUN);
    assign timeout = (state_q == SF_DONE);
endmodule

// File: rtl/host_wdt_supervisor.sv
// Top level: refresh edge detection, watchdog core and safety escalation.
// Assumes all inputs are synchronous to clk and that tick is a one-cycle enable.
module host_wdt_supervisor #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             host_refresh,
    input  logic             cell_above_weak,
    input  logic             charger_active,
    input  logic             fault_recover,
    input  logic [CNT_W-1:0] wdt_period,
    input  logic [CNT_W-1:0] safe_period,
    output logic             wdt_armed,
    output logic             wdt_expired,
    output logic             safe_running,
    output logic             safe_timeout
);
    logic refresh_rise;
    logic expire_pulse;
    logic escalate;

    hwd_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (host_refresh),
        .rise  (refresh_rise)
    );

    hwd_watchdog #(.CNT_W(CNT_W)) u_wdt (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick            (tick),
        .refresh_rise    (refresh_rise),
        .cell_above_weak (cell_above_weak),
        .recover         (fault_recover),
        .period          (wdt_period),
        .armed           (wdt_armed),
        .expired         (wdt_expired),
        .expire_pulse    (expire_pulse)
    );

    // Escalate only when the expiry happens during charging.
    assign escalate = expire_pulse && charger_active;

    hwd_safety #(.CNT_W(CNT_W)) u_safe (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .start   (escalate),
        .recover (fault_recover),
        .period  (safe_period),
        .running (safe_running),
        .timeout (safe_timeout)
    );
endmodule

// File: rtl/hwd_checker.sv
// Temporal checks on the supervisor ports, bound to every instance.
module hwd_checker (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic charger_active,
    input logic fault_recover,
    input logic wdt_armed,
    input logic wdt_expired,
    input logic safe_running,
    input logic safe_timeout
);
    // R2
    armed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_armed |=> wdt_armed);
    // R1
    no_expiry_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wdt_armed |=> !$rose(wdt_expired));
    // R3
    expiry_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !$rose(wdt_expired));
    // R5
    expired_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_expired && !fault_recover) |=> wdt_expired);
    // R6
    safe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(safe_running) |-> (wdt_expired && $past(charger_active)));
    // R7
    timeout_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(safe_timeout) |-> $past(safe_running));
    // R7
    timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (safe_timeout && !fault_recover) |=> (safe_timeout && !safe_running));
    // R8
    recover_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_recover |=> (!wdt_expired && !safe_running && !safe_timeout));
endmodule

bind host_wdt_supervisor hwd_checker u_hwd_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick           (tick),
    .charger_active (charger_active),
    .fault_recover  (fault_recover),
    .wdt_armed      (wdt_armed),
    .wdt_expired    (wdt_expired),
    .safe_running   (safe_running),
    .safe_timeout   (safe_timeout)
);

// File: tb/sim_host_wdt_supervisor.sv
module sim_host_wdt_supervisor;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic             host_refresh = 1'b0;
    logic             cell_above_weak = 1'b0;
    logic             charger_active = 1'b0;
    logic             fault_recover = 1'b0;
    logic [CNT_W-1:0] wdt_period = '0;
    logic [CNT_W-1:0] safe_period = '0;
    logic             wdt_armed, wdt_expired, safe_running, safe_timeout;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    host_wdt_supervisor #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .host_refresh(host_refresh),
        .cell_above_weak(cell_above_weak), .charger_active(charger_active),
        .fault_recover(fault_recover), .wdt_period(wdt_period),
        .safe_period(safe_period), .wdt_armed(wdt_armed),
        .wdt_expired(wdt_expired), .safe_running(safe_running),
        .safe_timeout(safe_timeout)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Advance one clock; inputs change and outputs are sampled 2 ns after the edge.
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic do_tick();
        tick = 1'b1;
        step();
        tick = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick = 1'b0; host_refresh = 1'b0; cell_above_weak = 1'b0;
        charger_active = 1'b0; fault_recover = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic pulse_recover();
        fault_recover = 1'b1;
        step();
        fault_recover = 1'b0;
    endtask

    task automatic run_all();
        // R9: reset state
        do_reset();
        check("R9 armed", wdt_armed, 0);
        check("R9 expired", wdt_expired, 0);
        check("R9 running", safe_running, 0);
        check("R9 timeout", safe_timeout, 0);

        // R1: ticks before arming do nothing
        wdt_period = 16'd2; charger_active = 1'b1;
        for (int i = 0; i < 30; i++) do_tick();
        check("R1 armed", wdt_armed, 0);
        check("R1 expired", wdt_expired, 0);
        check("R1 running", safe_running, 0);

        // R3/R6/R7 sweep over periods, arming cause and charger state
        for (int p = 1; p <= 5; p++) begin
            for (int s = 1; s <= 4; s++) begin
                for (int mode = 0; mode < 2; mode++) begin
                    automatic bit chg = ((p + s + mode) % 3) != 0;
                    do_reset();
                    wdt_period = p[CNT_W-1:0];
                    safe_period = s[CNT_W-1:0];
                    charger_active = chg;
                    if (mode == 1) host_refresh = 1'b1; else cell_above_weak = 1'b1;
                    step();
                    host_refresh = 1'b0;
                    check("R2 armed after cause", wdt_armed, 1);
                    for (int i = 1; i <= p; i++) begin
                        do_tick();
                        check("R3 expiry tick", wdt_expired, (i == p) ? 1 : 0);
                        check("R6 escalation", safe_running, (i == p && chg) ? 1 : 0);
                    end
                    if (chg) begin
                        for (int j = 1; j <= s; j++) begin
                            do_tick();
                            check("R7 timeout tick", safe_timeout, (j == s) ? 1 : 0);
                            check("R7 running", safe_running, (j < s) ? 1 : 0);
                        end
                    end else begin
                        for (int j = 0; j < 2 * p; j++) do_tick();
                        check("R6 idle charger no timer", safe_running, 0);
                        check("R6 idle charger no timeout", safe_timeout, 0);
                    end
                end
            end
        end

        // R4: refresh restarts, held level counts once
        do_reset();
        wdt_period = 16'd4; cell_above_weak = 1'b1; step();
        for (int i = 0; i < 3; i++) do_tick();
        host_refresh = 1'b1; step();      // rising edge, held high afterwards
        for (int i = 0; i < 3; i++) do_tick();
        check("R4 restart after refresh", wdt_expired, 0);
        do_tick();
        check("R4 held refresh counts once", wdt_expired, 1);
        host_refresh = 1'b0; step();

        // R4: refresh beats a tick in the same cycle
        do_reset();
        wdt_period = 16'd2; cell_above_weak = 1'b1; step();
        do_tick();
        host_refresh = 1'b1; tick = 1'b1; step(); tick = 1'b0; host_refresh = 1'b0;
        check("R4 refresh with tick", wdt_expired, 0);
        do_tick();
        check("R4 one tick after refresh", wdt_expired, 0);
        do_tick();
        check("R4 expiry after refresh", wdt_expired, 1);
        // R5: later refresh does not clear
        host_refresh = 1'b1; step(); host_refresh = 1'b0; step();
        check("R5 expired sticky", wdt_expired, 1);

        // R2: stays armed after the cell drops
        do_reset();
        cell_above_weak = 1'b1; step(); cell_above_weak = 1'b0;
        for (int i = 0; i < 5; i++) step();
        check("R2 armed sticky", wdt_armed, 1);

        // R3: period sampled only at restart
        do_reset();
        charger_active = 1'b0; wdt_period = 16'd3; cell_above_weak = 1'b1; step();
        wdt_period = 16'd10;
        for (int i = 0; i < 3; i++) do_tick();
        check("R3 old period kept", wdt_expired, 1);
        pulse_recover();
        check("R8 expired cleared", wdt_expired, 0);
        for (int i = 0; i < 9; i++) do_tick();
        check("R3 new period not yet", wdt_expired, 0);
        do_tick();
        check("R3 new period expiry", wdt_expired, 1);

        // R3: zero period behaves as one
        do_reset();
        wdt_period = 16'd0; cell_above_weak = 1'b1; step();
        check("R3 zero period no tick", wdt_expired, 0);
        do_tick();
        check("R3 zero period", wdt_expired, 1);

        // R7/R8: no restart after timeout, recovery re-enables escalation
        do_reset();
        wdt_period = 16'd2; safe_period = 16'd2; charger_active = 1'b1;
        cell_above_weak = 1'b1; step();
        do_tick(); do_tick();
        check("R6 running", safe_running, 1);
        do_tick(); do_tick();
        check("R7 timeout", safe_timeout, 1);
        for (int i = 0; i < 4; i++) do_tick();
        check("R7 no restart after timeout", safe_running, 0);
        check("R7 timeout held", safe_timeout, 1);
        pulse_recover();
        check("R8 timeout cleared", safe_timeout, 0);
        check("R8 expired cleared", wdt_expired, 0);
        check("R8 armed kept", wdt_armed, 1);
        host_refresh = 1'b1; step(); host_refresh = 1'b0;
        do_tick(); do_tick();
        check("R8 escalation again", safe_running, 1);
        pulse_recover();
        check("R8 running cleared", safe_running, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule